// File: doc/BRIEF.md
# Thermal Frequency Transition Arbiter

This block chooses which operating point the transition sequencer is asked to reach. Software writes load-based operating-point codes. A thermal-throttle input asks for a drop to the lowest frequency mode. The arbiter issues one target code at a time, with a one-cycle start strobe. It then waits for the sequencer's done handshake before it considers a new target.

A larger code means a higher frequency. The arbiter always remembers the most recent software code. While a thermal event is active, it aims for the lower of that code and the lowest-frequency code. A faster request therefore waits, and a slower one takes effect at once. When the thermal event ends, the most recent software code is restored. A status output tells the clock-modulation logic that a thermal drop is still in force, so that it can apply its own override rule.

Top module: `thermal_opp_arbiter`

## Requirements
- R1: After reset, `tgt_code` equals parameter `DFLT_CODE`, and `xfer_start` and `therm_active` are 0.
- R2: With no thermal event and no transition in flight, a software code different from `tgt_code` produces `xfer_start` high for exactly one cycle, in the cycle after the request. In that same cycle `tgt_code` equals the requested code.
- R3: A software code equal to the current `tgt_code`, with no thermal event, produces no `xfer_start`.
- R4: Only one transition is in flight at a time. After `xfer_start`, no further `xfer_start` occurs until `seq_done` has been seen. Software codes written meanwhile are recorded, and the most recent one becomes the next target.
- R5: When `therm_req` rises with the block settled and the target above the lowest mode, the block starts a transition to `LFM_CODE` and `therm_active` goes high.
- R6: While `therm_req` is high, the target is the lower of the latest software code and `LFM_CODE`. A software code higher than `LFM_CODE` starts no transition while the target is already `LFM_CODE`.
- R7: While `therm_req` is high, a software code lower than the current target starts a transition to that code at once. A later higher code moves the target back to `LFM_CODE`.
- R8: When `therm_req` falls, the block starts a transition to the most recent software code. Each deferred code overwrites any earlier deferred code.
- R9: `therm_active` stays high through the thermal hold. It drops in the cycle in which the restoring transition starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req_valid | input | 1 | Software operating-point write strobe |
| sw_req_code | input | CODE_W | Requested operating-point code (larger = faster) |
| therm_req | input | 1 | Thermal throttle request, level |
| seq_done | input | 1 | Sequencer finished the current transition |
| tgt_code | output | CODE_W | Target operating point issued to the sequencer |
| xfer_start | output | 1 | One-cycle transition start strobe |
| therm_active | output | 1 | Thermal frequency drop in force |

## Verification
The bench writes several codes while a transition is in flight. A design that issues the first of them, or starts before `seq_done`, is caught there. During a thermal hold it writes a faster code and checks that nothing starts; a design that compares codes the wrong way would jump out of the lowest mode. The bench applies a slower code, then a faster one, then a second faster one. A design that drops overwritten deferred requests, or restores the first deferred code, ends at the wrong target. Finally, `therm_active` is sampled during the hold and at the restore strobe. A flag cleared too early or too late shows up there.

// File: rtl/thermal_opp_arbiter.sv
module thermal_opp_arbiter #(
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] DFLT_CODE = 4'd8,
  parameter logic [CODE_W-1:0] LFM_CODE = 4'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_req_valid,
  input  logic [CODE_W-1:0] sw_req_code,
  input  logic              therm_req,
  input  logic              seq_done,
  output logic [CODE_W-1:0] tgt_code,
  output logic              xfer_start,
  output logic              therm_active
);

  typedef enum logic [1:0] {IDLE, XFER, HOLD, RESTORE} st_t;

  st_t st_q;
  logic [CODE_W-1:0] sw_last_q, cur_q;
  logic              start_q, therm_q;

  wire [CODE_W-1:0] sw_eff  = sw_req_valid ? sw_req_code : sw_last_q;
  wire [CODE_W-1:0] capped  = (sw_eff < LFM_CODE) ? sw_eff : LFM_CODE;
  wire [CODE_W-1:0] desired = therm_req ? capped : sw_eff;
  wire              settled = (st_q == IDLE) || (st_q == HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= IDLE;
      sw_last_q <= DFLT_CODE;
      cur_q     <= DFLT_CODE;
      start_q   <= 1'b0;
      therm_q   <= 1'b0;
    end else begin
      sw_last_q <= sw_eff;
      start_q   <= 1'b0;
      if (settled) begin
        therm_q <= therm_req;
        if (desired != cur_q) begin
          cur_q   <= desired;
          start_q <= 1'b1;
          st_q    <= (st_q == HOLD && !therm_req) ? RESTORE : XFER;
        end else begin
          st_q <= therm_req ? HOLD : IDLE;
        end
      end else if (seq_done) begin
        st_q <= therm_q ? HOLD : IDLE;
      end
    end
  end

  assign tgt_code     = cur_q;
  assign xfer_start   = start_q;
  assign therm_active = therm_q;

endmodule

module thermal_opp_arbiter_chk #(
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] LFM_CODE = 4'd2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_done,
  input logic [CODE_W-1:0] tgt_code,
  input logic              xfer_start,
  input logic              therm_active
);

  logic busy_q;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else if (xfer_start) busy_q <= 1'b1;
    else if (seq_done) busy_q <= 1'b0;
  end

  // R4
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !xfer_start);

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  // R2
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_start |-> $stable(tgt_code));

  // R5
  therm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(therm_active) |-> tgt_code <= LFM_CODE);

  // R6
  therm_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_active && xfer_start) |-> tgt_code <= LFM_CODE);

endmodule

bind thermal_opp_arbiter thermal_opp_arbiter_chk #(.CODE_W(CODE_W), .LFM_CODE(LFM_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .tgt_code(tgt_code),
  .xfer_start(xfer_start), .therm_active(therm_active)
);

// File: tb/thermal_opp_arbiter_bench.sv
module thermal_opp_arbiter_bench;
  localparam int CW = 4;
  logic clk = 0, rst_n = 0;
  logic sw_req_valid = 0, therm_req = 0, seq_done = 0;
  logic [CW-1:0] sw_req_code = 0;
  logic [CW-1:0] tgt_code;
  logic xfer_start, therm_active;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  thermal_opp_arbiter u_thermal_opp_arbiter (
    .clk(clk), .rst_n(rst_n), .sw_req_valid(sw_req_valid), .sw_req_code(sw_req_code),
    .therm_req(therm_req), .seq_done(seq_done), .tgt_code(tgt_code),
    .xfer_start(xfer_start), .therm_active(therm_active)
  );

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sw_write(int code);
    sw_req_valid = 1; sw_req_code = CW'(code);
    tick();
    sw_req_valid = 0;
  endtask

  task automatic done_pulse();
    seq_done = 1; tick(); seq_done = 0;
  endtask

  task automatic quiet(string req, int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      if (xfer_start) seen++;
      tick();
    end
    chk(req, seen, 0);
  endtask

  task automatic t_reset();
    chk("R1 tgt", tgt_code, 8);
    chk("R1 start", xfer_start, 0);
    chk("R1 therm", therm_active, 0);
  endtask

  task automatic t_basic();
    sw_write(5);
    chk("R2 start", xfer_start, 1);
    chk("R2 tgt", tgt_code, 5);
    tick();
    chk("R2 pulse width", xfer_start, 0);
    done_pulse();
    tick();
    sw_write(5);
    quiet("R3 same code", 4);
    chk("R3 tgt", tgt_code, 5);
  endtask

  task automatic t_inflight();
    sw_write(10);
    chk("R4 first start", xfer_start, 1);
    tick();
    sw_write(12);
    sw_write(11);
    quiet("R4 busy", 3);
    chk("R4 tgt held", tgt_code, 10);
    done_pulse();
    tick();
    chk("R4 next start", xfer_start, 1);
    chk("R4 latest code", tgt_code, 11);
    tick();
    done_pulse();
    tick();
  endtask

  task automatic t_thermal();
    therm_req = 1;
    tick();
    chk("R5 start", xfer_start, 1);
    chk("R5 tgt", tgt_code, 2);
    chk("R5 therm", therm_active, 1);
    tick();
    done_pulse();
    sw_write(9);
    quiet("R6 faster deferred", 4);
    chk("R6 tgt", tgt_code, 2);
    chk("R9 hold", therm_active, 1);
    sw_write(1);
    chk("R7 slower start", xfer_start, 1);
    chk("R7 tgt", tgt_code, 1);
    tick();
    done_pulse();
    sw_write(9);
    chk("R7 back to lowest", tgt_code, 2);
    chk("R7 start", xfer_start, 1);
    tick();
    done_pulse();
    sw_write(7);
    quiet("R8 deferred", 2);
    therm_req = 0;
    tick();
    chk("R8 restore start", xfer_start, 1);
    chk("R8 restore tgt", tgt_code, 7);
    chk("R9 drop", therm_active, 0);
    tick();
    done_pulse();
    quiet("R8 settled", 3);
  endtask

  initial begin
    fork
      begin
        tick(); tick();
        t_reset();
        rst_n = 1;
        tick();
        t_reset();
        t_basic();
        t_inflight();
        t_thermal();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule